// File: doc/BRIEF.md
# Serial Port Control Register with Banked Mode and Error Status

This block holds the control and status register of a byte-oriented serial port. Three bit positions at the top of the register are shared by two sets of storage. One set is the three mode-select bits that configure the shift engines. The other set is three sticky error flags: framing error, receive overrun and transmit collision. A view-select input comes from a separate power-control register and decides which set the CPU reads and writes through those positions. The five lower bit positions are plain storage. The block passes them through to the rest of the port.

The transmitter and receiver report events through single-cycle strobes. These strobes are a CPU write to the transmit buffer while the transmitter is busy, a byte latched into the receive buffer together with its sampled stop bit, and a CPU read of the receive buffer. The block turns these strobes into error flags. A flag stays set until software clears it in the status view.

Top module: `uart_ctl_bank`

## Requirements
- R1: After a synchronous active-low reset, all stored state is zero: mode bits, error flags, low bits and the unread-byte tracker. With either view selected, `ctl_rdata` reads 0x00.
- R2: With `status_view`=0, a write through `ctl_wr` stores `ctl_wdata[7:5]` as the mode field. `ctl_rdata[7:5]` returns the mode field, and `mode_o[2:0]` carries the same value: bit 2 is mode bit 0, bit 1 is mode bit 1 and bit 0 is mode bit 2. The serial mode number is {mode_o[2], mode_o[1]}.
- R3: With `status_view`=1, `ctl_rdata[7]` returns the framing-error flag, `ctl_rdata[6]` returns the overrun flag and `ctl_rdata[5]` returns the collision flag.
- R4: Bits 4:0 are stored on every `ctl_wr`, whatever the view. They read back on `ctl_rdata[4:0]` and drive `ctl_low_o`.
- R5: In every serial mode, a `txbuf_wr` pulse while `tx_busy`=1 sets the collision flag at the next edge.
- R6: When the serial mode number is not 0, the overrun flag is set by an `rx_latch` that arrives while the unread tracker is set and `rxbuf_rd` is low in the same cycle. In serial mode 0 the overrun flag is never set.
- R7: When the serial mode number is not 0, an `rx_latch` with `rx_stop`=0 sets the framing-error flag. In serial mode 0 the framing-error flag is never set.
- R8: The error flags are sticky. A flag is cleared only by a `ctl_wr` with `status_view`=1 that writes 0 to its position. Writing 1 to that position leaves the flag as it was, and so does any write with `status_view`=0.
- R9: A write with `status_view`=1 leaves the mode field unchanged. Changing `status_view` alters no stored bit.
- R10: If a set event and a CPU clear reach the same flag in one cycle, the flag ends set.
- R11: Each `rx_latch` sets the unread tracker. An `rxbuf_rd` without a latch in the same cycle clears it. When both happen in the same cycle, the tracker ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | CPU write strobe for the control register |
| ctl_wdata | input | 8 | CPU write data |
| ctl_rdata | output | 8 | Register read value for the selected view |
| status_view | input | 1 | View select: 1 selects the error flags, 0 selects the mode bits |
| txbuf_wr | input | 1 | CPU write of the transmit data buffer |
| tx_busy | input | 1 | Transmitter is shifting a frame |
| rx_latch | input | 1 | Receiver latched a byte into the receive buffer |
| rx_stop | input | 1 | Sampled stop bit, valid with rx_latch |
| rxbuf_rd | input | 1 | CPU read of the receive buffer |
| mode_o | output | 3 | Stored mode field, to the shift engines |
| ctl_low_o | output | 5 | Stored bits 4:0, to the rest of the port |

## Verification
The bench builds the block with its default widths: an 8-bit register, a 3-bit shared field and 5 plain low bits. At this size every write value can be applied in both views, and every combination of the seven strobe and view inputs can be applied from each of the four serial modes. These sweeps reach the same-cycle collisions, such as set against clear and latch against read, together with the gating in mode 0. An arithmetic model in the bench predicts the flags, the tracker and the read value for each cycle.

// File: rtl/uart_bank_pkg.sv
// Package: shared widths and flag index positions for the banked control register.
// Assumes the shared field sits directly above the plain low bits.
package uart_bank_pkg;
    localparam int REG_W   = 8;
    localparam int SHR_W   = 3;
    localparam int LOW_W   = REG_W - SHR_W;
    // flag indices inside the shared field (index 2 maps to the top register bit)
    localparam int IDX_COL = 0;
    localparam int IDX_OVR = 1;
    localparam int IDX_FE  = 2;
    typedef logic [SHR_W-1:0] shr_t;
endpackage

// File: rtl/uart_err_detect.sv
// Module: turns transmitter and receiver strobes into one-cycle set requests
// for the three error flags. It also keeps the unread-byte tracker.
// Assumes the strobes are single-cycle and synchronous to clk.
module uart_err_detect
    import uart_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_nz,
    input  logic txbuf_wr,
    input  logic tx_busy,
    input  logic rx_latch,
    input  logic rx_stop,
    input  logic rxbuf_rd,
    output shr_t set_req
);
    logic unread_q;

    // unread tracker: a latch sets it, a read alone clears it
    always_ff @(posedge clk) begin
        if (!rst_n)        unread_q <= 1'b0;
        else if (rx_latch) unread_q <= 1'b1;
        else if (rxbuf_rd) unread_q <= 1'b0;
    end

    // set requests; receive-side detectors are gated off in serial mode 0
    always_comb begin
        set_req          = '0;
        set_req[IDX_COL] = txbuf_wr && tx_busy;
        set_req[IDX_OVR] = mode_nz && rx_latch && unread_q && !rxbuf_rd;
        set_req[IDX_FE]  = mode_nz && rx_latch && !rx_stop;
    end

    assert_latch_marks_unread_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_latch |=> unread_q);
    assert_read_clears_unread_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rxbuf_rd && !rx_latch) |=> !unread_q);
endmodule

// File: rtl/uart_sticky_flag.sv
// Module: one sticky error flag. A set request wins over a clear request in the same cycle.
// Assumes set and clr are evaluated in the same clock domain.
module uart_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // hold the flag; a set has priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
endmodule

// File: rtl/uart_ctl_bank.sv
// Module: control register of the serial port. Bits 7:5 are banked between the
// mode field and the error flags, and status_view selects the bank. Bits 4:0 are plain storage.
// Assumes status_view is stable around each ctl_wr.
module uart_ctl_bank
    import uart_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic             status_view,
    input  logic             txbuf_wr,
    input  logic             tx_busy,
    input  logic             rx_latch,
    input  logic             rx_stop,
    input  logic             rxbuf_rd,
    output logic [SHR_W-1:0] mode_o,
    output logic [LOW_W-1:0] ctl_low_o
);
    shr_t             mode_q;
    shr_t             flag_q;
    shr_t             set_req;
    shr_t             clr_req;
    logic [LOW_W-1:0] low_q;
    logic             mode_nz;

    // serial mode number is {mode bit 0, mode bit 1}; non-zero enables receive checks
    always_comb mode_nz = mode_q[SHR_W-1] | mode_q[SHR_W-2];

    // mode field: written only through the mode view
    always_ff @(posedge clk) begin
        if (!rst_n)                      mode_q <= '0;
        else if (ctl_wr && !status_view) mode_q <= ctl_wdata[REG_W-1 -: SHR_W];
    end

    // plain low bits: written on every register write
    always_ff @(posedge clk) begin
        if (!rst_n)      low_q <= '0;
        else if (ctl_wr) low_q <= ctl_wdata[LOW_W-1:0];
    end

    uart_err_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_nz  (mode_nz),
        .txbuf_wr (txbuf_wr),
        .tx_busy  (tx_busy),
        .rx_latch (rx_latch),
        .rx_stop  (rx_stop),
        .rxbuf_rd (rxbuf_rd),
        .set_req  (set_req)
    );

    // clear requests: a write of 0 through the status view
    always_comb clr_req = (ctl_wr && status_view) ? ~ctl_wdata[REG_W-1 -: SHR_W] : '0;

    for (genvar i = 0; i < SHR_W; i++) begin : g_flag
        uart_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_req[i]),
            .clr   (clr_req[i]),
            .q     (flag_q[i])
        );
    end

    // read mux: the view select picks the bank for the shared positions
    always_comb ctl_rdata = {(status_view ? flag_q : mode_q), low_q};

    assign mode_o    = mode_q;
    assign ctl_low_o = low_q;

    assert_mode_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(mode_q));
    assert_mode_hold_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && status_view) |=> $stable(mode_q));
    assert_no_rx_err_mode0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_nz && !flag_q[IDX_OVR] && !(ctl_wr && !status_view)) |=> !flag_q[IDX_OVR]);
    assert_collision_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (txbuf_wr && tx_busy) |=> flag_q[IDX_COL]);
endmodule

// File: tb/uart_ctl_bank_bench.sv
module uart_ctl_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 0, status_view = 0, txbuf_wr = 0, tx_busy = 0;
    logic       rx_latch = 0, rx_stop = 1, rxbuf_rd = 0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic [2:0] mode_o;
    logic [4:0] ctl_low_o;

    int checks = 0;
    int errors = 0;

    // bench model of the stored state
    logic [2:0] m_mode = '0;
    logic [2:0] m_flag = '0;   // {fe, ovr, col}
    logic [4:0] m_low  = '0;
    logic       m_unread = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_ctl_bank u_uart_ctl_bank (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .status_view(status_view), .txbuf_wr(txbuf_wr),
        .tx_busy(tx_busy), .rx_latch(rx_latch), .rx_stop(rx_stop),
        .rxbuf_rd(rxbuf_rd), .mode_o(mode_o), .ctl_low_o(ctl_low_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare all outputs against the model for the current view
    task automatic check_all(input string tag);
        logic [7:0] exp_rd;
        exp_rd = {(status_view ? m_flag : m_mode), m_low};
        check(tag, {8'h0, ctl_rdata}, {8'h0, exp_rd});
        check(tag, {13'h0, mode_o}, {13'h0, m_mode});
        check(tag, {11'h0, ctl_low_o}, {11'h0, m_low});
    endtask

    // drive one cycle of stimulus, update the model at the edge, check after it
    task automatic step(input logic cw, input logic [7:0] wd, input logic vw,
                        input logic tw, input logic bz, input logic lt,
                        input logic sp, input logic rd, input string tag);
        logic       nz;
        logic [2:0] set_v, clr_v;
        @(negedge clk);
        ctl_wr = cw; ctl_wdata = wd; status_view = vw; txbuf_wr = tw;
        tx_busy = bz; rx_latch = lt; rx_stop = sp; rxbuf_rd = rd;
        nz       = m_mode[2] | m_mode[1];
        set_v[0] = tw & bz;
        set_v[1] = nz & lt & m_unread & ~rd;
        set_v[2] = nz & lt & ~sp;
        clr_v    = (cw & vw) ? ~wd[7:5] : 3'b000;
        @(posedge clk);
        m_flag   = set_v | (m_flag & ~clr_v);
        m_unread = lt | (m_unread & ~rd);
        if (cw && !vw) m_mode = wd[7:5];
        if (cw) m_low = wd[4:0];
        #1;
        check_all(tag);
        @(negedge clk);
        ctl_wr = 0; txbuf_wr = 0; rx_latch = 0; rxbuf_rd = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state in both views
        status_view = 0; #1; check_all("R1 mode view");
        status_view = 1; #1; check_all("R1 status view");

        // R2 R3 R4 R8 R9: every write value through both views
        for (int v = 0; v < 2; v++)
            for (int d = 0; d < 256; d++) begin
                step(1'b1, 8'(d), v[0], 0, 0, 0, 1, 0, "R2 R3 R4 R8 R9 sweep");
                status_view = ~v[0]; #1; check_all("R9 view switch");
            end

        // R5 R6 R7 R8 R10 R11: all strobe combinations from each serial mode
        for (int m = 0; m < 4; m++)
            for (int e = 0; e < 128; e++) begin
                step(1'b1, {m[1:0], 1'b0, 5'(e)}, 1'b0, 0, 0, 0, 1, 0, "R2 mode set");
                step(e[5], 8'(e * 37), e[6], e[0], e[1], e[2], e[3], e[4],
                     "R5 R6 R7 R8 R10 R11 combo");
                step(1'b0, 8'h00, 1'b1, 0, 0, e[2], 1, 0, "R6 R11 follow-up latch");
                step(1'b1, 8'h00, 1'b1, 0, 0, 0, 1, 1, "R8 clear");
            end

        // R10 directed: collision set and clear in the same cycle
        step(1'b1, 8'h00, 1'b1, 1, 1, 0, 1, 0, "R10 set beats clear");
        check("R10 flag", {15'h0, ctl_rdata[5]}, 16'h1);
        // R8 directed: writing 1 keeps the flag, writing 0 clears it
        step(1'b1, 8'hE0, 1'b1, 0, 0, 0, 1, 0, "R8 write one");
        check("R8 kept", {15'h0, ctl_rdata[5]}, 16'h1);
        step(1'b1, 8'h00, 1'b1, 0, 0, 0, 1, 0, "R8 write zero");
        check("R8 cleared", {15'h0, ctl_rdata[5]}, 16'h0);
        // R6 R11 directed: mode 1, two latches without a read give an overrun
        step(1'b1, 8'h40, 1'b0, 0, 0, 0, 1, 0, "R2 mode 1");
        step(1'b0, 8'h00, 1'b1, 0, 0, 1, 1, 1, "R11 latch");
        step(1'b0, 8'h00, 1'b1, 0, 0, 1, 1, 0, "R6 second latch");
        check("R6 overrun", {15'h0, ctl_rdata[6]}, 16'h1);
        // R7 directed: low stop bit in mode 1
        step(1'b0, 8'h00, 1'b1, 0, 0, 1, 0, 1, "R7 bad stop");
        check("R7 framing", {15'h0, ctl_rdata[7]}, 16'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule